// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block conditions a small number of asynchronous interrupt pins coming from outside the chip. Each pin has its own output toward the interrupt controller. A pin first passes through a two-flop synchroniser. An optional glitch filter may follow it. A detector then works in one of four sense modes: high level, low level, rising edge or falling edge.

Edge events are held in a sticky pending bit until software acknowledges them. Level events pass through for as long as the line is enabled.

Software sets each line through one 32-bit configuration word on a simple register port. Reads are combinational and writes take effect at the clock edge. A change to the enable or to the filter settings takes a few cycles to settle, and a busy flag shows this. Setting the enable takes effect only when busy clears. Clearing the enable masks the line at once.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, every `irq_out` bit is 0 and every configuration word reads 0.
- R2: The configuration word of line n is at byte address 4·(n+1), and the acknowledge register is at address 0.
  - Field positions: enable at bit 16, level select at bit 9, polarity at bit 8, filter enable at bit 4, filter length select at bits [1:0].
  - All other bits are ignored on write and read 0, including bit 31.
  - A write to an address with no register has no effect.
- R3: Sense mode is set by {level select, polarity}:
  - 11 gives active-high level.
  - 10 gives active-low level.
  - 01 gives rising edge.
  - 00 gives falling edge.
- R4: Busy flag behaviour:
  - A write that changes the enable, the filter enable or the filter select makes bit n of line n's word read 1 for exactly 3 cycles after the write edge. While busy is set, that bit reads 1; otherwise it reads the stored field.
  - A newly set enable and new filter settings act only once busy clears.
  - A write that changes only polarity or level select does not set busy.
- R5: With the filter off:
  - A level output changes at the second clock edge after the pin changes.
  - An edge event shows as pending at the third edge.
- R6: With the filter on, its length is 2^(select+1) cycles (2, 4, 8 or 16).
  - A pin pulse shorter than the length is dropped, and one of exactly the length passes.
  - A level output changes at edge L+2 after the pin changes.
- R7: An edge event stays pending on `irq_out` until 1 is written to bit n of the acknowledge register. Writing 0, or acknowledging a different line, leaves it set.
- R8: In level mode the output follows the qualified pin in both directions while the line is enabled.
- R9: A write that clears the enable drops the output and discards any pending event at that write edge. Re-enabling does not bring the old event back.
- R10: Writing 0 to a configuration word disables the line and clears all of its fields.
- R11: If a new edge event and an acknowledge for the same line land on the same edge, the event wins and stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ext_pin | input | NUM_LINES (2) | Asynchronous external interrupt pins |
| irq_out | output | NUM_LINES (2) | One conditioned interrupt per line |

## Verification
Counted from the first rising edge after a pin change, the results fall due as follows:
- An unfiltered level output is due at edge 2.
- An unfiltered pending event is due at edge 3.
- A filtered level output is due at edge L+2.
- Busy reads 1 right after a write edge and for two more cycles, and 0 after the third.

The bench drives every input 1 ns after a rising edge and steps a whole cycle at a time. It samples both one step before and at the due step, so an off-by-one latency fails. Sticky and masking behaviour is checked by reading `irq_out` after each acknowledge or disable write and before any further stimulus.

// File: rtl/eic_pkg.sv
// Package: shared field positions and configuration type for the
// external interrupt line conditioner.
// Assumes a 32-bit register port; the field positions are fixed by software.
package eic_pkg;
    localparam int REG_W    = 32;
    localparam int SEL_W    = 2;
    localparam int BIT_EN   = 16;
    localparam int BIT_LVL  = 9;
    localparam int BIT_POL  = 8;
    localparam int BIT_GFEN = 4;

    typedef struct packed {
        logic             en;
        logic             lvl;
        logic             pol;
        logic             gfen;
        logic [SEL_W-1:0] gfsel;
    } line_cfg_t;

    // Extract the meaningful fields from a written word.
    function automatic line_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        line_cfg_t c;
        c.en    = w[BIT_EN];
        c.lvl   = w[BIT_LVL];
        c.pol   = w[BIT_POL];
        c.gfen  = w[BIT_GFEN];
        c.gfsel = w[SEL_W-1:0];
        return c;
    endfunction

    // Place the fields back at their word positions.
    function automatic logic [REG_W-1:0] pack_cfg(input line_cfg_t c);
        logic [REG_W-1:0] w;
        w                = '0;
        w[BIT_EN]        = c.en;
        w[BIT_LVL]       = c.lvl;
        w[BIT_POL]       = c.pol;
        w[BIT_GFEN]      = c.gfen;
        w[SEL_W-1:0]     = c.gfsel;
        return w;
    endfunction
endpackage

// File: rtl/eic_sync.sv
// Module: eic_sync
// Brings one asynchronous pin into the clock domain through a chain of
// STAGES flops. Assumes the pin is slow enough that one sample is not lost.
module eic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/eic_glitch_filter.sv
// Module: eic_glitch_filter
// Passes a new input value to the output only after it has been seen for
// 2^(sel+1) consecutive samples. Assumes sel is quasi-static; if sel shrinks
// mid-count the pending change is taken on the next sample.
module eic_glitch_filter #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             din,
    output logic             dout
);
    localparam int MAX_LEN = 2 << ((1 << SEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LEN);

    logic [CNT_W:0]   len_full;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] run_cnt;

    // Terminal count for the selected length.
    always_comb begin
        len_full = (CNT_W+1)'(2) << sel;
        lim      = CNT_W'(len_full - 1'b1);
    end

    // Count consecutive disagreeing samples, adopt the input at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            dout    <= 1'b0;
        end else if (din == dout) begin
            run_cnt <= '0;
        end else if (run_cnt >= lim) begin
            dout    <= din;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R6: the output only ever moves to the value the input held.
    p_filter_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> (dout == $past(din)));
endmodule

// File: rtl/eic_line.sv
// Module: eic_line
// One interrupt line: configuration word, settle (busy) counter, synchroniser,
// optional filter and level/edge detector. Assumes writes and acknowledges
// are single-cycle strobes from the register decoder.
module eic_line
    import eic_pkg::*;
#(
    parameter int LINE_IDX    = 0,
    parameter int BUSY_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             ack,
    input  logic             pin,
    output logic [REG_W-1:0] rdata,
    output logic             irq
);
    localparam int BC_W = $clog2(BUSY_CYCLES + 1);

    line_cfg_t        cfg;
    line_cfg_t        new_cfg;
    logic [BC_W-1:0]  busy_cnt;
    logic             busy;
    logic             settle_chg;
    logic             act_gfen;
    logic [SEL_W-1:0] act_gfsel;
    logic             act_en;
    logic             sync_q;
    logic             filt_q;
    logic             q;
    logic             q_d;
    logic             edge_evt;
    logic             pending;

    assign new_cfg    = unpack_cfg(wdata);
    assign settle_chg = cfg_wr && ((new_cfg.en != cfg.en) || (new_cfg.gfen != cfg.gfen)
                                   || (new_cfg.gfsel != cfg.gfsel));
    assign busy       = (busy_cnt != '0);
    assign act_en     = cfg.en && !busy;

    // Hold the software view of the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (cfg_wr) cfg <= new_cfg;
    end

    // Settle counter: restart on a relevant change, otherwise run down.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_cnt <= '0;
        else if (settle_chg) busy_cnt <= BC_W'(BUSY_CYCLES);
        else if (busy)       busy_cnt <= busy_cnt - 1'b1;
    end

    // Copy filter settings into the filter as the settle window ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_gfen  <= 1'b0;
            act_gfsel <= '0;
        end else if (busy_cnt == BC_W'(1)) begin
            act_gfen  <= cfg.gfen;
            act_gfsel <= cfg.gfsel;
        end
    end

    eic_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (pin),
        .dout (sync_q)
    );

    eic_glitch_filter #(.SEL_W(SEL_W)) u_filt (
        .clk (clk),
        .rst_n (rst_n),
        .sel (act_gfsel),
        .din (sync_q),
        .dout (filt_q)
    );

    assign q = act_gfen ? filt_q : sync_q;

    // Remember the previous qualified value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) q_d <= 1'b0;
        else        q_d <= q;
    end

    assign edge_evt = cfg.pol ? (q && !q_d) : (!q && q_d);

    // Sticky pending bit: disable clears, new event beats acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pending <= 1'b0;
        else if (cfg_wr && !new_cfg.en)     pending <= 1'b0;
        else if (!cfg.en || cfg.lvl)        pending <= 1'b0;
        else if (edge_evt && act_en)        pending <= 1'b1;
        else if (ack)                       pending <= 1'b0;
    end

    assign irq   = act_en && (cfg.lvl ? (q == cfg.pol) : pending);
    assign rdata = pack_cfg(cfg) | (REG_W'(busy) << LINE_IDX);

    // R4: a relevant change always raises busy.
    p_busy_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        settle_chg |=> busy);
    // R4: the settle window never exceeds its length.
    p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= BC_W'(BUSY_CYCLES));
    // R9: clearing the enable silences the line at the write edge.
    p_disable_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !new_cfg.en) |=> (!pending && !irq));
    // R7: an acknowledge with no competing event clears the pending bit.
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !edge_evt) |=> !pending);
endmodule

// File: rtl/ext_irq_cond.sv
// Module: ext_irq_cond (top)
// Register decoder and NUM_LINES conditioned interrupt lines. Address 0 is
// the write-one acknowledge register; line n sits at 4*(n+1). Assumes
// ADDR_W is wide enough to reach the last line.
module ext_irq_cond
    import eic_pkg::*;
#(
    parameter int NUM_LINES   = 2,
    parameter int ADDR_W      = 4,
    parameter int BUSY_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NUM_LINES-1:0] ext_pin,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [REG_W-1:0]     line_rd [NUM_LINES];
    logic [NUM_LINES-1:0] cfg_wr_vec;
    logic [NUM_LINES-1:0] ack_vec;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign cfg_wr_vec[i] = reg_wr && (reg_addr == ADDR_W'((i + 1) * 4));
        assign ack_vec[i]    = reg_wr && (reg_addr == '0) && reg_wdata[i];

        eic_line #(
            .LINE_IDX    (i),
            .BUSY_CYCLES (BUSY_CYCLES)
        ) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_wr (cfg_wr_vec[i]),
            .wdata  (reg_wdata),
            .ack    (ack_vec[i]),
            .pin    (ext_pin[i]),
            .rdata  (line_rd[i]),
            .irq    (irq_out[i])
        );
    end

    // Read mux: configuration words only, everything else reads 0.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (reg_addr == ADDR_W'((i + 1) * 4)) reg_rdata = line_rd[i];
        end
    end

    // R2: at most one configuration word is written per cycle.
    p_one_cfg_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_wr_vec));
endmodule

// File: tb/ext_irq_cond_test.sv
`timescale 1ns/1ps
module ext_irq_cond_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  ext_pin = '0;
    logic [1:0]  irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_irq_cond uut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .ext_pin (ext_pin), .irq_out (irq_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1", "irq after reset", 32'(irq_out), 32'h0);
        rd(4'h4, v); chk("R1", "line0 word", v, 32'h0);
        rd(4'h8, v); chk("R1", "line1 word", v, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(4'h8, 32'h8001_0313);
        step(4);
        rd(4'h8, v); chk("R2", "line1 readback", v, 32'h0001_0313);
        rd(4'h4, v); chk("R2", "line0 untouched", v, 32'h0);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'h8, v); chk("R2", "unmapped write line1", v, 32'h0001_0313);
        rd(4'h4, v); chk("R2", "unmapped write line0", v, 32'h0);
        wr(4'h8, 32'h0);
        step(4);
        rd(4'h8, v); chk("R10", "zero write clears line1", v, 32'h0);
        chk("R10", "line1 quiet", 32'(irq_out[1]), 32'h0);
    endtask

    task automatic t_busy;
        logic [31:0] v;
        ext_pin[0] = 1'b1;
        step(4);
        wr(4'h4, 32'h0001_0300);
        for (int k = 0; k < 3; k++) begin
            rd(4'h4, v);
            chk("R4", "busy bit during settle", 32'(v[0]), 32'h1);
            chk("R4", "enable deferred while busy", 32'(irq_out[0]), 32'h0);
            step();
        end
        rd(4'h4, v); chk("R4", "busy clears after 3", 32'(v[0]), 32'h0);
        chk("R3", "active-high level asserted", 32'(irq_out[0]), 32'h1);
        ext_pin[0] = 1'b0;
        step(); chk("R8", "level still high 1 edge", 32'(irq_out[0]), 32'h1);
        step(); chk("R8", "level follows low", 32'(irq_out[0]), 32'h0);
        ext_pin[0] = 1'b1;
        step(3);
        wr(4'h4, 32'h0001_0200);
        rd(4'h4, v); chk("R4", "polarity-only write not busy", 32'(v[0]), 32'h0);
        chk("R3", "active-low idle with pin high", 32'(irq_out[0]), 32'h0);
        ext_pin[0] = 1'b0;
        step(); chk("R5", "level 1 edge after pin", 32'(irq_out[0]), 32'h0);
        step(); chk("R5", "level 2 edges after pin", 32'(irq_out[0]), 32'h1);
    endtask

    task automatic t_edge;
        wr(4'h4, 32'h0001_0100);
        step(3);
        ext_pin[0] = 1'b1;
        step(2); chk("R5", "edge not yet pending", 32'(irq_out[0]), 32'h0);
        step();  chk("R5", "edge pending at 3rd edge", 32'(irq_out[0]), 32'h1);
        ext_pin[0] = 1'b0;
        step(5); chk("R7", "pending sticky", 32'(irq_out[0]), 32'h1);
        wr(4'h0, 32'h2); chk("R7", "other line ack", 32'(irq_out[0]), 32'h1);
        wr(4'h0, 32'h0); chk("R7", "zero ack", 32'(irq_out[0]), 32'h1);
        wr(4'h0, 32'h1); chk("R7", "ack clears", 32'(irq_out[0]), 32'h0);
    endtask

    task automatic t_same_cycle;
        ext_pin[0] = 1'b1; step(4);
        ext_pin[0] = 1'b0; step(4);
        chk("R11", "pending before race", 32'(irq_out[0]), 32'h1);
        ext_pin[0] = 1'b1;
        step(2);
        wr(4'h0, 32'h1);
        chk("R11", "event beats ack", 32'(irq_out[0]), 32'h1);
        wr(4'h0, 32'h1);
        chk("R11", "later ack clears", 32'(irq_out[0]), 32'h0);
    endtask

    task automatic t_falling;
        wr(4'h4, 32'h0001_0000);
        step(3);
        ext_pin[0] = 1'b0; step(4);
        chk("R3", "falling edge pending", 32'(irq_out[0]), 32'h1);
        wr(4'h0, 32'h1);
        ext_pin[0] = 1'b1; step(4);
        chk("R3", "rising ignored in falling mode", 32'(irq_out[0]), 32'h0);
    endtask

    task automatic t_disable;
        wr(4'h4, 32'h0001_0100);
        ext_pin[0] = 1'b0; step(4);
        ext_pin[0] = 1'b1; step(4);
        chk("R9", "pending before disable", 32'(irq_out[0]), 32'h1);
        wr(4'h4, 32'h0000_0100);
        chk("R9", "masked at write edge", 32'(irq_out[0]), 32'h0);
        wr(4'h4, 32'h0001_0100);
        step(5);
        chk("R9", "old event discarded", 32'(irq_out[0]), 32'h0);
    endtask

    task automatic t_filter;
        wr(4'h8, 32'h0001_0111);
        step(5);
        ext_pin[1] = 1'b1; step(3); ext_pin[1] = 1'b0;
        step(10); chk("R6", "3-cycle pulse dropped (L=4)", 32'(irq_out[1]), 32'h0);
        ext_pin[1] = 1'b1; step(4); ext_pin[1] = 1'b0;
        step(10); chk("R6", "4-cycle pulse passes (L=4)", 32'(irq_out[1]), 32'h1);
        wr(4'h0, 32'h2);
        chk("R7", "line1 ack", 32'(irq_out[1]), 32'h0);
        wr(4'h8, 32'h0001_0310);
        step(5);
        ext_pin[1] = 1'b1;
        step(3); chk("R6", "L=2 level not yet", 32'(irq_out[1]), 32'h0);
        step();  chk("R6", "L=2 level at edge 4", 32'(irq_out[1]), 32'h1);
        ext_pin[1] = 1'b0;
        step(8);
        wr(4'h8, 32'h0001_0313);
        step(5);
        ext_pin[1] = 1'b1;
        step(17); chk("R6", "L=16 level not yet", 32'(irq_out[1]), 32'h0);
        step();   chk("R6", "L=16 level at edge 18", 32'(irq_out[1]), 32'h1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_map();
        t_busy();
        t_edge();
        t_same_cycle();
        t_falling();
        t_disable();
        t_filter();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule